// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between a microcontroller core's data-memory port and the physical storage behind it. For each request it picks one target: the low internal RAM, the high internal RAM, the special function register (SFR) space, a 256-byte on-chip expansion RAM, or the off-chip bus. It also forms the address that target receives, and it returns that target's read data to the core. The core says how the operand was addressed. A direct access to 80H–FFH means registers. An indirect access there means high RAM, and stack pushes and pops are sent as indirect accesses. A move-external access is split between the on-chip expansion RAM and the external bus. A mode bit and the upper byte of the effective address decide the split.

The block owns a few registers in the SFR space, which the core reaches with direct accesses. These are two 16-bit data pointers, a one-bit pointer select and the expansion-RAM mode bit. A read of any other register address returns 00H. Routing, address formation and read data are all combinational. Register writes take effect at the rising clock edge.

Top module: `dmem_router`

## Requirements
- R1: With `accType` 0 (direct) or 1 (indirect), an address in 00H–7FH with a strobe asserts `lowSel`, and `tgtAddr` equals {00H, `addr`}.
- R2: An address in 80H–FFH asserts `sfrSel` for `accType` 0 and `upSel` for `accType` 1. In both cases `tgtAddr` equals {00H, `addr`}.
- R3: With `accType` 2 (move-external through an 8-bit register pointer) and the mode bit clear, `eramSel` is asserted and `tgtAddr` equals {00H, `addr`}.
- R4: With `accType` 3 (move-external through the selected data pointer) and the mode bit clear, a pointer value of 0000H–00FFH asserts `eramSel`, and `tgtAddr` equals the pointer value.
- R5: With `accType` 3, a pointer value of 0100H–FFFFH asserts `extReq`, whatever the mode bit is, and `tgtAddr` equals the pointer value.
- R6: With the mode bit set, every access of `accType` 2 or 3 asserts `extReq` and never `eramSel`.
- R7: At most one of the five selects is high in any cycle. With `rdEn` and `wrEn` both low, no select is high.
- R8: Direct writes to 82H and 83H load the low and high byte of pointer 0. Direct writes to 84H and 85H load the low and high byte of pointer 1. Direct reads at these addresses return the stored bytes.
- R9: Bit 0 of the register at direct address A2H selects the pointer that `accType` 3 uses (0 = pointer 0, 1 = pointer 1). A read of A2H returns the bit in bit 0 and zeros in all other bits.
- R10: Bit 1 of the register at direct address 8EH is the expansion-RAM mode bit (1 = all move-external accesses go off-chip). A read of 8EH returns the bit in bit 1 and zeros in all other bits.
- R11: After reset both pointers are 0000H, the pointer select is 0 and the mode bit is 0.
- R12: When `rdEn` is high, `rdData` carries the selected target's read input: `lowRdData`, `upRdData`, `eramRdData` or `extRdData`, or the owned register for an SFR read. An SFR read at an address the block does not own returns 00H. When `rdEn` is low, `rdData` is 00H.
- R13: Indirect writes to 80H–FFH, and direct writes to unowned register addresses, leave the pointers, the select bit and the mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accType | input | 2 | 0 direct, 1 indirect, 2 move-external by 8-bit pointer, 3 move-external by data pointer |
| addr | input | 8 | Operand address from the core |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data (used by the owned registers) |
| lowRdData | input | 8 | Read data from low internal RAM |
| upRdData | input | 8 | Read data from high internal RAM |
| eramRdData | input | 8 | Read data from the expansion RAM |
| extRdData | input | 8 | Read data from the external bus |
| lowSel | output | 1 | Low internal RAM selected |
| upSel | output | 1 | High internal RAM selected |
| sfrSel | output | 1 | Register space selected |
| eramSel | output | 1 | Expansion RAM selected |
| extReq | output | 1 | External bus access requested |
| tgtAddr | output | 16 | Address presented to the selected target |
| rdData | output | 8 | Read data returned to the core |

## Verification
The bound checker watches the routing on every cycle. It checks that at most one select is active, that there is no select without a strobe, and that the low, high and register space are chosen from the address and access type. It also checks that a data-pointer address above 00FFH always goes off-chip, that pointer byte loads take effect on the next cycle, and that indirect writes never touch the pointers. The bench scenarios cover the rest, because that behaviour depends on register history. This covers the effect of the select and mode bits on move-external routing, the 00FFH/0100H boundary, register read-back with masked bits, the 00H returned for unowned registers, and the reset values.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_XREG     = 2'd2,
    ACC_XPTR     = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    LR_NONE = 3'd0,
    LR_P0LO = 3'd1,
    LR_P0HI = 3'd2,
    LR_P1LO = 3'd3,
    LR_P1HI = 3'd4,
    LR_PSEL = 3'd5,
    LR_MODE = 3'd6
  } localReg_t;

  typedef struct packed {
    logic      lowSel;
    logic      upSel;
    logic      sfrSel;
    logic      eramSel;
    logic      extSel;
    logic      usePtr;
    logic      regWr;
    localReg_t regId;
  } strobe_t;

  localparam logic [7:0] SFR_P0LO = 8'h82;
  localparam logic [7:0] SFR_P0HI = 8'h83;
  localparam logic [7:0] SFR_P1LO = 8'h84;
  localparam logic [7:0] SFR_P1HI = 8'h85;
  localparam logic [7:0] SFR_PSEL = 8'hA2;
  localparam logic [7:0] SFR_MODE = 8'h8E;
  localparam int PSEL_BIT = 0;
  localparam int MODE_BIT = 1;

endpackage

// File: rtl/dmr_ctrl.sv
module dmr_ctrl
  import dmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        accType,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              extMode,
  input  logic              ptrInPage0,
  output strobe_t           stb
);

  logic      active;
  logic      lowHalf;
  accKind_t  kind;
  localReg_t regDec;

  assign active  = rdEn | wrEn;
  assign lowHalf = ~addr[ADDR_W-1];
  assign kind    = accKind_t'(accType);

  always_comb begin
    regDec = LR_NONE;
    if (!lowHalf) begin
      case (addr)
        ADDR_W'(SFR_P0LO): regDec = LR_P0LO;
        ADDR_W'(SFR_P0HI): regDec = LR_P0HI;
        ADDR_W'(SFR_P1LO): regDec = LR_P1LO;
        ADDR_W'(SFR_P1HI): regDec = LR_P1HI;
        ADDR_W'(SFR_PSEL): regDec = LR_PSEL;
        ADDR_W'(SFR_MODE): regDec = LR_MODE;
        default:           regDec = LR_NONE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.regId  = regDec;
    stb.usePtr = (kind == ACC_XPTR);
    if (active) begin
      case (kind)
        ACC_DIRECT: begin
          if (lowHalf) stb.lowSel = 1'b1;
          else begin
            stb.sfrSel = 1'b1;
            stb.regWr  = wrEn && (regDec != LR_NONE);
          end
        end
        ACC_INDIRECT: begin
          if (lowHalf) stb.lowSel = 1'b1;
          else         stb.upSel  = 1'b1;
        end
        ACC_XREG: begin
          if (extMode) stb.extSel  = 1'b1;
          else         stb.eramSel = 1'b1;
        end
        default: begin
          if (!extMode && ptrInPage0) stb.eramSel = 1'b1;
          else                        stb.extSel  = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/dmr_datapath.sv
module dmr_datapath
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int XADDR_W = 16,
  parameter int DATA_W  = 8,
  parameter int NPTR    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  lowRd,
  input  logic [DATA_W-1:0]  upRd,
  input  logic [DATA_W-1:0]  eramRd,
  input  logic [DATA_W-1:0]  extRd,
  output logic               extMode,
  output logic               ptrInPage0,
  output logic [XADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0]  rdData
);

  localparam int PAGE_W = XADDR_W - ADDR_W;
  localparam int HI_W   = XADDR_W - DATA_W;
  localparam int SEL_W  = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [NPTR-1:0][XADDR_W-1:0] ptrQ;
  logic [SEL_W-1:0]             selQ;
  logic                         modeQ;
  logic [XADDR_W-1:0]           selPtr;
  logic [DATA_W-1:0]            regRd;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam localReg_t ID_LO = (i == 0) ? LR_P0LO : LR_P1LO;
    localparam localReg_t ID_HI = (i == 0) ? LR_P0HI : LR_P1HI;
    always_ff @(posedge clk) begin
      if (!rstN) ptrQ[i] <= '0;
      else if (stb.regWr && stb.regId == ID_LO) ptrQ[i][DATA_W-1:0] <= wrData;
      else if (stb.regWr && stb.regId == ID_HI) ptrQ[i][XADDR_W-1:DATA_W] <= HI_W'(wrData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      modeQ <= 1'b0;
    end else if (stb.regWr) begin
      if (stb.regId == LR_PSEL) selQ  <= SEL_W'(wrData[PSEL_BIT]);
      if (stb.regId == LR_MODE) modeQ <= wrData[MODE_BIT];
    end
  end

  assign selPtr     = ptrQ[selQ];
  assign extMode    = modeQ;
  assign ptrInPage0 = (selPtr[XADDR_W-1:ADDR_W] == '0);
  assign tgtAddr    = stb.usePtr ? selPtr : {{PAGE_W{1'b0}}, addr};

  always_comb begin
    regRd = '0;
    case (stb.regId)
      LR_P0LO: regRd = ptrQ[0][DATA_W-1:0];
      LR_P0HI: regRd = DATA_W'(ptrQ[0][XADDR_W-1:DATA_W]);
      LR_P1LO: regRd = ptrQ[NPTR-1][DATA_W-1:0];
      LR_P1HI: regRd = DATA_W'(ptrQ[NPTR-1][XADDR_W-1:DATA_W]);
      LR_PSEL: regRd[PSEL_BIT] = selQ[0];
      LR_MODE: regRd[MODE_BIT] = modeQ;
      default: regRd = '0;
    endcase
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if      (stb.lowSel)  rdData = lowRd;
      else if (stb.upSel)   rdData = upRd;
      else if (stb.sfrSel)  rdData = regRd;
      else if (stb.eramSel) rdData = eramRd;
      else if (stb.extSel)  rdData = extRd;
    end
  end

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int XADDR_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         accType,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  lowRdData,
  input  logic [DATA_W-1:0]  upRdData,
  input  logic [DATA_W-1:0]  eramRdData,
  input  logic [DATA_W-1:0]  extRdData,
  output logic               lowSel,
  output logic               upSel,
  output logic               sfrSel,
  output logic               eramSel,
  output logic               extReq,
  output logic [XADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0]  rdData
);

  strobe_t stb;
  logic    extMode;
  logic    ptrInPage0;

  dmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .accType    (accType),
    .addr       (addr),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .extMode    (extMode),
    .ptrInPage0 (ptrInPage0),
    .stb        (stb)
  );

  dmr_datapath #(
    .ADDR_W  (ADDR_W),
    .XADDR_W (XADDR_W),
    .DATA_W  (DATA_W),
    .NPTR    (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addr       (addr),
    .rdEn       (rdEn),
    .wrData     (wrData),
    .lowRd      (lowRdData),
    .upRd       (upRdData),
    .eramRd     (eramRdData),
    .extRd      (extRdData),
    .extMode    (extMode),
    .ptrInPage0 (ptrInPage0),
    .tgtAddr    (tgtAddr),
    .rdData     (rdData)
  );

  assign lowSel  = stb.lowSel;
  assign upSel   = stb.upSel;
  assign sfrSel  = stb.sfrSel;
  assign eramSel = stb.eramSel;
  assign extReq  = stb.extSel;

endmodule

// File: rtl/dmr_checker.sv
module dmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  accType,
  input logic [7:0]  addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic        lowSel,
  input logic        upSel,
  input logic        sfrSel,
  input logic        eramSel,
  input logic        extReq,
  input logic [15:0] tgtAddr,
  input logic [15:0] ptr0,
  input logic [15:0] ptr1
);

  logic strobe;
  assign strobe = rdEn | wrEn;

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowSel, upSel, sfrSel, eramSel, extReq}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |-> !(lowSel | upSel | sfrSel | eramSel | extReq));

  p_low_half_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !accType[1] && !addr[7]) |-> (lowSel && tgtAddr == {8'h00, addr}));

  p_upper_split_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !accType[1] && addr[7]) |-> (accType[0] ? upSel : sfrSel));

  p_far_ptr_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && accType == 2'd3 && tgtAddr[15:8] != 8'h00) |-> extReq);

  p_regptr_page0_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && accType == 2'd2) |-> (tgtAddr[15:8] == 8'h00 && (eramSel || extReq)));

  p_ptr_lo_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accType == 2'd0 && addr == 8'h82) |=> (ptr0[7:0] == $past(wrData)));

  p_ptr_hi_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accType == 2'd0 && addr == 8'h85) |=> (ptr1[15:8] == $past(wrData)));

  p_indirect_keeps_ptr_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accType == 2'd1) |=> ($stable(ptr0) && $stable(ptr1)));

endmodule

bind dmem_router dmr_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .accType (accType),
  .addr    (addr),
  .rdEn    (rdEn),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .lowSel  (lowSel),
  .upSel   (upSel),
  .sfrSel  (sfrSel),
  .eramSel (eramSel),
  .extReq  (extReq),
  .tgtAddr (tgtAddr),
  .ptr0    (u_dp.ptrQ[0]),
  .ptr1    (u_dp.ptrQ[1])
);

// File: tb/dmem_router_test.sv
module dmem_router_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accType = '0;
  logic [7:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  lowRdData  = 8'h11;
  logic [7:0]  upRdData   = 8'h22;
  logic [7:0]  eramRdData = 8'h33;
  logic [7:0]  extRdData  = 8'h44;
  logic        lowSel, upSel, sfrSel, eramSel, extReq;
  logic [15:0] tgtAddr;
  logic [7:0]  rdData;

  always #2.5 clk = ~clk;

  dmem_router uut (
    .clk(clk), .rstN(rstN), .accType(accType), .addr(addr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .lowRdData(lowRdData), .upRdData(upRdData),
    .eramRdData(eramRdData), .extRdData(extRdData),
    .lowSel(lowSel), .upSel(upSel), .sfrSel(sfrSel),
    .eramSel(eramSel), .extReq(extReq), .tgtAddr(tgtAddr), .rdData(rdData)
  );

  typedef struct {
    string       tag;
    logic [4:0]  sel;
    logic        chkAddr;
    logic [15:0] ta;
    logic [7:0]  rd;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // bench-side model of the owned registers
  logic [15:0] mPtr0 = '0, mPtr1 = '0;
  logic        mSel = 1'b0, mMode = 1'b0;

  function automatic logic [7:0] regValue(input logic [7:0] a);
    case (a)
      8'h82: return mPtr0[7:0];
      8'h83: return mPtr0[15:8];
      8'h84: return mPtr1[7:0];
      8'h85: return mPtr1[15:8];
      8'hA2: return {7'b0, mSel};
      8'h8E: return {6'b0, mMode, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic access(input logic [1:0] k, input logic [7:0] a,
                        input logic r, input logic w, input logic [7:0] d,
                        input string tag);
    exp_t e;
    logic [15:0] p;
    @(negedge clk);
    accType = k; addr = a; rdEn = r; wrEn = w; wrData = d;
    e.tag = tag; e.sel = 5'b0; e.chkAddr = r | w; e.ta = {8'h00, a}; e.rd = 8'h00;
    if (r | w) begin
      case (k)
        2'd0: e.sel = a[7] ? 5'b00100 : 5'b10000;
        2'd1: e.sel = a[7] ? 5'b01000 : 5'b10000;
        2'd2: e.sel = mMode ? 5'b00001 : 5'b00010;
        default: begin
          p = mSel ? mPtr1 : mPtr0;
          e.ta = p;
          e.sel = (!mMode && p[15:8] == 8'h00) ? 5'b00010 : 5'b00001;
        end
      endcase
    end
    if (r) begin
      case (e.sel)
        5'b10000: e.rd = 8'h11;
        5'b01000: e.rd = 8'h22;
        5'b00100: e.rd = regValue(a);
        5'b00010: e.rd = 8'h33;
        5'b00001: e.rd = 8'h44;
        default:  e.rd = 8'h00;
      endcase
    end
    q.push_back(e);
    if (w && k == 2'd0) begin
      case (a)
        8'h82: mPtr0[7:0]  = d;
        8'h83: mPtr0[15:8] = d;
        8'h84: mPtr1[7:0]  = d;
        8'h85: mPtr1[15:8] = d;
        8'hA2: mSel  = d[0];
        8'h8E: mMode = d[1];
        default: ;
      endcase
    end
  endtask

  initial begin : monitor
    exp_t e;
    logic [4:0] got;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        got = {lowSel, upSel, sfrSel, eramSel, extReq};
        total++;
        if (got !== e.sel || rdData !== e.rd || (e.chkAddr && tgtAddr !== e.ta)) begin
          bad++;
          $display("FAIL %s: sel=%b ta=%h rd=%h expected sel=%b ta=%h rd=%h",
                   e.tag, got, tgtAddr, rdData, e.sel, e.ta, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11 reset values
    access(2'd0, 8'h82, 1, 0, 8'h00, "R11 ptr0 lo after reset");
    access(2'd0, 8'h83, 1, 0, 8'h00, "R11 ptr0 hi after reset");
    access(2'd0, 8'h84, 1, 0, 8'h00, "R11 ptr1 lo after reset");
    access(2'd0, 8'h85, 1, 0, 8'h00, "R11 ptr1 hi after reset");
    access(2'd0, 8'hA2, 1, 0, 8'h00, "R11 select after reset");
    access(2'd0, 8'h8E, 1, 0, 8'h00, "R11 mode after reset");
    access(2'd3, 8'h00, 1, 0, 8'h00, "R11 ptr access to eram after reset");

    // R1 low half
    access(2'd0, 8'h05, 1, 0, 8'h00, "R1 direct low read");
    access(2'd1, 8'h7F, 1, 0, 8'h00, "R1 indirect low boundary");
    access(2'd1, 8'h20, 0, 1, 8'h5A, "R1 indirect low write");

    // R2 upper split, R12 unmapped register read
    access(2'd0, 8'h80, 1, 0, 8'h00, "R2 R12 direct unowned reads 00");
    access(2'd1, 8'h80, 1, 0, 8'h00, "R2 indirect upper boundary");
    access(2'd1, 8'hC0, 0, 1, 8'h77, "R2 stack push lands in upper ram");

    // R8 pointer loads and read-back
    access(2'd0, 8'h82, 0, 1, 8'h34, "R8 write ptr0 lo");
    access(2'd0, 8'h83, 0, 1, 8'h12, "R8 write ptr0 hi");
    access(2'd0, 8'h84, 0, 1, 8'hCD, "R8 write ptr1 lo");
    access(2'd0, 8'h85, 0, 1, 8'h00, "R8 write ptr1 hi");
    access(2'd0, 8'h82, 1, 0, 8'h00, "R8 read ptr0 lo");
    access(2'd0, 8'h83, 1, 0, 8'h00, "R8 read ptr0 hi");
    access(2'd0, 8'h84, 1, 0, 8'h00, "R8 read ptr1 lo");

    // R5 / R9 pointer select
    access(2'd3, 8'h00, 1, 0, 8'h00, "R5 ptr0 1234 goes external");
    access(2'd0, 8'hA2, 0, 1, 8'hFF, "R9 set select");
    access(2'd0, 8'hA2, 1, 0, 8'h00, "R9 select readback masked");
    access(2'd3, 8'h00, 1, 0, 8'h00, "R4 R9 ptr1 00CD goes to eram");

    // R13 writes that must not touch owned registers
    access(2'd1, 8'h84, 0, 1, 8'hFF, "R13 indirect write at 84");
    access(2'd0, 8'h84, 1, 0, 8'h00, "R13 ptr1 lo unchanged");
    access(2'd0, 8'h90, 0, 1, 8'hEE, "R13 direct write unowned");
    access(2'd0, 8'h82, 1, 0, 8'h00, "R13 ptr0 lo unchanged");
    access(2'd1, 8'h8E, 0, 1, 8'h02, "R13 indirect write at 8E");
    access(2'd2, 8'h40, 1, 0, 8'h00, "R13 R3 mode still clear, reg pointer to eram");

    // R3 register pointer to eram
    access(2'd2, 8'hFF, 0, 1, 8'h99, "R3 reg pointer write to eram");

    // R10 / R6 mode bit
    access(2'd0, 8'h8E, 0, 1, 8'hFF, "R10 set mode");
    access(2'd0, 8'h8E, 1, 0, 8'h00, "R10 mode readback masked");
    access(2'd2, 8'h40, 1, 0, 8'h00, "R6 reg pointer goes external");
    access(2'd3, 8'h00, 1, 0, 8'h00, "R6 low data pointer goes external");
    access(2'd0, 8'h8E, 0, 1, 8'h00, "R10 clear mode");
    access(2'd3, 8'h00, 1, 0, 8'h00, "R4 eram again after clear");

    // R4 / R5 page boundary on pointer 0
    access(2'd0, 8'hA2, 0, 1, 8'h00, "R9 select ptr0");
    access(2'd0, 8'h83, 0, 1, 8'h00, "R4 ptr0 hi 00");
    access(2'd0, 8'h82, 0, 1, 8'hFF, "R4 ptr0 lo FF");
    access(2'd3, 8'h00, 1, 0, 8'h00, "R4 ptr 00FF boundary eram");
    access(2'd0, 8'h83, 0, 1, 8'h01, "R5 ptr0 hi 01");
    access(2'd0, 8'h82, 0, 1, 8'h00, "R5 ptr0 lo 00");
    access(2'd3, 8'h00, 0, 1, 8'h55, "R5 ptr 0100 boundary external");

    // R7 / R12 strobes
    access(2'd3, 8'h90, 0, 0, 8'h00, "R7 no strobe no select");
    access(2'd1, 8'hA0, 0, 1, 8'h01, "R12 write gives zero read data");

    access(2'd0, 8'h00, 0, 0, 8'h00, "R7 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule